// File: doc/BRIEF.md
# Synchronous Receiver Character-Alignment Hunter

This block finds character boundaries in a synchronous serial bit stream. When software issues the hunt command while the receiver is enabled, the block samples the data line at every receive-clock strobe and compares the most recent character-length bits with a programmed sync pattern after every new bit. Alignment is therefore found at any bit offset, not only at multiples of the character length. With double sync selected, a second programmed pattern has to follow directly after the first. When the sequence completes, the block raises a sticky sync-detected flag. A status read clears that flag.

Once aligned, the block counts character boundaries from the end of the sync sequence. For each completed character it emits a one-cycle valid pulse with the data right-justified and a parity-error flag. In external alignment mode the internal comparison is disabled. Alignment is instead taken from a rising edge on a dedicated sync input, and the first data bit is the one sampled at the next receive-clock strobe.

All logic runs on one system clock. The receive-clock rising edge arrives as a one-cycle strobe `bit_tick`, and `rxd` is sampled in that cycle.

Top module: `sync_hunt_rx`

## Requirements
- R1: After reset, `syndet`, `hunting` and `char_valid` are all low.
- R2: A `hunt_cmd` pulse makes `hunting` high on the next cycle only if `rx_enable` is high; with `rx_enable` low the command has no effect.
- R3: The serial stream is received least-significant bit first. While hunting, the comparison is repeated after every sampled bit, so a sync pattern is found at any bit offset. Only the low `len` bits of each sync pattern take part, where `len` = 5, 6, 7 or 8 for `len_code` = 0, 1, 2, 3.
- R4: With `single_sync` = 1 and parity disabled, `syndet` rises and `hunting` falls in the cycle after the strobe that carries the last bit of the sync pattern.
- R5: With `single_sync` = 0, hunting ends only when the bits that follow the first pattern match `sync_char2`. On a mismatch the block keeps hunting bit by bit for `sync_char1`.
- R6: With `parity_en` = 1, each sync pattern is followed by one parity bit, and `syndet` is raised only after the parity bit of the final sync pattern.
- R7: After alignment, every `len` data bits (plus one parity bit when enabled) produce a one-cycle `char_valid` pulse, with `char_data` holding the character LSB-aligned and zero above bit `len`-1.
- R8: With `parity_en` = 1, `char_par_err` is high when the received parity bit differs from the expected one. With `parity_even` = 1 the expected bit makes the count of ones over data and parity even; with `parity_even` = 0 it makes that count odd.
- R9: `syndet` stays high until a `status_rd` pulse, which clears it on the next cycle.
- R10: With `ext_mode` = 1, a pattern on `rxd` never ends the hunt. A rising edge on `sync_in` ends it on the next cycle without raising `syndet`, and data assembly starts with the next strobe.
- R11: Whenever `rx_enable` is low, the block leaves hunting and produces no `char_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle strobe for a rising receive-clock edge |
| rxd | input | 1 | Serial data, sampled when `bit_tick` is high |
| rx_enable | input | 1 | Receiver enable |
| hunt_cmd | input | 1 | Pulse: restart character-alignment hunt |
| len_code | input | 2 | Character length code, length = 5 + code |
| parity_en | input | 1 | One parity bit follows each character |
| parity_even | input | 1 | 1 = even parity, 0 = odd parity |
| single_sync | input | 1 | 1 = one sync pattern, 0 = two in sequence |
| ext_mode | input | 1 | 1 = alignment taken from `sync_in` |
| sync_in | input | 1 | External alignment input, rising edge active |
| sync_char1 | input | 8 | First sync pattern |
| sync_char2 | input | 8 | Second sync pattern |
| status_rd | input | 1 | Pulse: status read, clears `syndet` |
| char_valid | output | 1 | One-cycle pulse per assembled character |
| char_data | output | 8 | Assembled character |
| char_par_err | output | 1 | Parity error for `char_data` |
| syndet | output | 1 | Sticky sync-detected flag |
| hunting | output | 1 | High while alignment is being sought |

## Verification
Every result of a strobe is due one system clock after the cycle in which `bit_tick` is high. This holds for the rise of `syndet`, the fall of `hunting` and each `char_valid` pulse. An external `sync_in` edge, a `status_rd` pulse and a `hunt_cmd` each act one clock after the cycle that carries them. The bench changes inputs on falling clock edges, holds each strobe for exactly one cycle, and samples the outputs on the next falling edge, so every check looks at the cycle in which its result is due. Characters are compared by a scoreboard monitor on the falling edge of every cycle, so a pulse that arrives early, late or unexpectedly is also caught.

// File: rtl/sync_hunt_pkg.sv
`timescale 1ns/1ps
package sync_hunt_pkg;

    localparam int CHAR_W = 8;
    localparam int CNT_W  = 4;
    localparam int MIN_LEN = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HUNT,
        ST_SKIP1,
        ST_SYNC2,
        ST_SKIP2,
        ST_DATA
    } hunt_state_t;

    typedef struct packed {
        logic [1:0] len_code;
        logic       parity_en;
        logic       parity_even;
        logic       single_sync;
        logic       ext_mode;
    } rx_cfg_t;

    typedef struct packed {
        logic [CHAR_W-1:0] data;
        logic              par_err;
    } rx_char_t;

    function automatic logic [CNT_W-1:0] char_bits(input logic [1:0] code);
        return CNT_W'(MIN_LEN) + CNT_W'(code);
    endfunction

    function automatic logic [CHAR_W-1:0] len_mask(input logic [1:0] code);
        logic [CHAR_W:0] one_hot;
        one_hot = (CHAR_W+1)'(1) << char_bits(code);
        return CHAR_W'(one_hot - (CHAR_W+1)'(1));
    endfunction

    // right-justify the newest len bits of an MSB-entry shift register
    function automatic logic [CHAR_W-1:0] window(input logic [CHAR_W-1:0] sr,
                                                 input logic [1:0] code);
        return sr >> (CHAR_W - int'(char_bits(code)));
    endfunction

    function automatic logic want_parity(input logic [CHAR_W-1:0] data,
                                         input logic even);
        return even ? (^data) : ~(^data);
    endfunction

endpackage

// File: rtl/sync_hunt_shifter.sv
`timescale 1ns/1ps
module sync_hunt_shifter
    import sync_hunt_pkg::*;
#(
    parameter int W  = CHAR_W,
    parameter int CW = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         rxd,
    input  logic         clr_fill,
    input  logic [1:0]   len_code,
    output logic [W-1:0] win_next,
    output logic         full_next
);
    logic [W-1:0]  sr;
    logic [W-1:0]  sr_next;
    logic [CW-1:0] fill;
    logic [CW:0]   fill_inc;

    assign sr_next   = tick ? {rxd, sr[W-1:1]} : sr;
    assign win_next  = window(sr_next, len_code);
    assign fill_inc  = {1'b0, fill} + (CW+1)'(1);
    assign full_next = fill_inc >= {1'b0, char_bits(len_code)};

    always_ff @(posedge clk) begin
        if (rst) begin
            sr   <= '0;
            fill <= '0;
        end else begin
            sr <= sr_next;
            if (clr_fill) begin
                fill <= '0;
            end else if (tick && fill != CW'(W)) begin
                fill <= fill + CW'(1);
            end
        end
    end
endmodule

// File: rtl/sync_hunt_matcher.sv
`timescale 1ns/1ps
module sync_hunt_matcher
    import sync_hunt_pkg::*;
#(
    parameter int W = CHAR_W
) (
    input  logic [W-1:0] win,
    input  logic [W-1:0] pat1,
    input  logic [W-1:0] pat2,
    input  logic [1:0]   len_code,
    output logic         hit1,
    output logic         hit2
);
    logic [W-1:0] mask;

    assign mask = len_mask(len_code);
    assign hit1 = win == (pat1 & mask);
    assign hit2 = win == (pat2 & mask);
endmodule

// File: rtl/sync_hunt_assembler.sv
`timescale 1ns/1ps
module sync_hunt_assembler
    import sync_hunt_pkg::*;
#(
    parameter int W  = CHAR_W,
    parameter int CW = CNT_W
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       active,
    input  logic       start,
    input  logic       tick,
    input  logic       rxd,
    input  logic [1:0] len_code,
    input  logic       parity_en,
    input  logic       parity_even,
    output logic       valid,
    output rx_char_t   char_out
);
    logic [CW-1:0] cnt;
    logic [W-1:0]  acc;
    logic [W-1:0]  acc_next;
    logic [CW-1:0] nbits;
    logic [CW-1:0] last_idx;
    logic          in_data;

    assign nbits    = char_bits(len_code);
    assign last_idx = parity_en ? nbits : nbits - CW'(1);
    assign in_data  = cnt < nbits;
    assign acc_next = in_data ? (acc | (W'(rxd) << cnt)) : acc;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            acc      <= '0;
            valid    <= 1'b0;
            char_out <= '0;
        end else begin
            valid <= 1'b0;
            if (start) begin
                cnt <= '0;
                acc <= '0;
            end else if (active && tick) begin
                if (cnt == last_idx) begin
                    valid            <= 1'b1;
                    char_out.data    <= acc_next;
                    char_out.par_err <= parity_en &&
                                        (rxd != want_parity(acc_next, parity_even));
                    cnt              <= '0;
                    acc              <= '0;
                end else begin
                    cnt <= cnt + CW'(1);
                    acc <= acc_next;
                end
            end
        end
    end
endmodule

// File: rtl/sync_hunt_rx.sv
`timescale 1ns/1ps
module sync_hunt_rx
    import sync_hunt_pkg::*;
#(
    parameter int W = CHAR_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         bit_tick,
    input  logic         rxd,
    input  logic         rx_enable,
    input  logic         hunt_cmd,
    input  logic [1:0]   len_code,
    input  logic         parity_en,
    input  logic         parity_even,
    input  logic         single_sync,
    input  logic         ext_mode,
    input  logic         sync_in,
    input  logic [W-1:0] sync_char1,
    input  logic [W-1:0] sync_char2,
    input  logic         status_rd,
    output logic         char_valid,
    output logic [W-1:0] char_data,
    output logic         char_par_err,
    output logic         syndet,
    output logic         hunting
);
    rx_cfg_t     cfg;
    hunt_state_t st, st_n;
    logic [W-1:0] win_next;
    logic        full_next;
    logic        hit1, hit2;
    logic        clr_fill, asm_start, lock;
    logic        sync_q, sync_rise;
    logic        asm_active;
    rx_char_t    asm_char;

    assign cfg = '{len_code:    len_code,
                   parity_en:   parity_en,
                   parity_even: parity_even,
                   single_sync: single_sync,
                   ext_mode:    ext_mode};

    assign sync_rise  = sync_in && !sync_q;
    assign asm_active = (st == ST_DATA) && rx_enable && !hunt_cmd;
    assign hunting    = (st == ST_HUNT) || (st == ST_SKIP1) ||
                        (st == ST_SYNC2) || (st == ST_SKIP2);

    sync_hunt_shifter #(.W(W), .CW(CNT_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .tick      (bit_tick),
        .rxd       (rxd),
        .clr_fill  (clr_fill),
        .len_code  (cfg.len_code),
        .win_next  (win_next),
        .full_next (full_next)
    );

    sync_hunt_matcher #(.W(W)) u_match (
        .win      (win_next),
        .pat1     (sync_char1),
        .pat2     (sync_char2),
        .len_code (cfg.len_code),
        .hit1     (hit1),
        .hit2     (hit2)
    );

    sync_hunt_assembler #(.W(W), .CW(CNT_W)) u_asm (
        .clk         (clk),
        .rst         (rst),
        .active      (asm_active),
        .start       (asm_start),
        .tick        (bit_tick),
        .rxd         (rxd),
        .len_code    (cfg.len_code),
        .parity_en   (cfg.parity_en),
        .parity_even (cfg.parity_even),
        .valid       (char_valid),
        .char_out    (asm_char)
    );

    assign char_data    = asm_char.data;
    assign char_par_err = asm_char.par_err;

    // the sync sequence ends: either go to the second pattern or lock
    always_comb begin
        st_n      = st;
        clr_fill  = 1'b0;
        asm_start = 1'b0;
        lock      = 1'b0;
        if (!rx_enable) begin
            st_n = ST_IDLE;
        end else if (hunt_cmd) begin
            st_n     = ST_HUNT;
            clr_fill = 1'b1;
        end else begin
            case (st)
                ST_HUNT: begin
                    if (cfg.ext_mode) begin
                        if (sync_rise) begin
                            st_n      = ST_DATA;
                            asm_start = 1'b1;
                        end
                    end else if (bit_tick && full_next && hit1) begin
                        if (cfg.parity_en) begin
                            st_n = ST_SKIP1;
                        end else if (cfg.single_sync) begin
                            st_n      = ST_DATA;
                            asm_start = 1'b1;
                            lock      = 1'b1;
                        end else begin
                            st_n     = ST_SYNC2;
                            clr_fill = 1'b1;
                        end
                    end
                end
                ST_SKIP1: begin
                    if (bit_tick) begin
                        if (cfg.single_sync) begin
                            st_n      = ST_DATA;
                            asm_start = 1'b1;
                            lock      = 1'b1;
                        end else begin
                            st_n     = ST_SYNC2;
                            clr_fill = 1'b1;
                        end
                    end
                end
                ST_SYNC2: begin
                    if (bit_tick && full_next) begin
                        if (!hit2) begin
                            st_n = ST_HUNT;
                        end else if (cfg.parity_en) begin
                            st_n = ST_SKIP2;
                        end else begin
                            st_n      = ST_DATA;
                            asm_start = 1'b1;
                            lock      = 1'b1;
                        end
                    end
                end
                ST_SKIP2: begin
                    if (bit_tick) begin
                        st_n      = ST_DATA;
                        asm_start = 1'b1;
                        lock      = 1'b1;
                    end
                end
                ST_IDLE, ST_DATA: st_n = st;
                default: st_n = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            sync_q <= 1'b0;
            syndet <= 1'b0;
        end else begin
            st     <= st_n;
            sync_q <= sync_in;
            if (lock) begin
                syndet <= 1'b1;
            end else if (status_rd) begin
                syndet <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/sync_hunt_chk.sv
`timescale 1ns/1ps
module sync_hunt_chk (
    input logic clk,
    input logic rst,
    input logic rx_enable,
    input logic hunt_cmd,
    input logic bit_tick,
    input logic status_rd,
    input logic syndet,
    input logic hunting,
    input logic char_valid
);
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!syndet && !hunting && !char_valid)); // R1

    AST_HUNT_NEEDS_CMD: assert property (@(posedge clk) disable iff (rst)
        $rose(hunting) |-> ($past(hunt_cmd) && $past(rx_enable))); // R2

    AST_SYNDET_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        $rose(syndet) |-> ($past(bit_tick) && $past(rx_enable))); // R4

    AST_STATUS_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (syndet && status_rd && !bit_tick) |=> !syndet); // R9

    AST_SYNDET_STICKY: assert property (@(posedge clk) disable iff (rst)
        (syndet && !status_rd) |=> syndet); // R9

    AST_VALID_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        char_valid |-> ($past(bit_tick) && $past(rx_enable))); // R7

    AST_VALID_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        char_valid |-> !hunting); // R7

    AST_OFF_NO_HUNT: assert property (@(posedge clk) disable iff (rst)
        !rx_enable |=> !hunting); // R11
endmodule

bind sync_hunt_rx sync_hunt_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .rx_enable  (rx_enable),
    .hunt_cmd   (hunt_cmd),
    .bit_tick   (bit_tick),
    .status_rd  (status_rd),
    .syndet     (syndet),
    .hunting    (hunting),
    .char_valid (char_valid)
);

// File: tb/sync_hunt_rx_test.sv
`timescale 1ns/1ps
module sync_hunt_rx_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_tick = 1'b0;
    logic       rxd = 1'b1;
    logic       rx_enable = 1'b0;
    logic       hunt_cmd = 1'b0;
    logic [1:0] len_code = 2'd3;
    logic       parity_en = 1'b0;
    logic       parity_even = 1'b1;
    logic       single_sync = 1'b1;
    logic       ext_mode = 1'b0;
    logic       sync_in = 1'b0;
    logic [7:0] sync_char1 = 8'h16;
    logic [7:0] sync_char2 = 8'h16;
    logic       status_rd = 1'b0;
    logic       char_valid;
    logic [7:0] char_data;
    logic       char_par_err;
    logic       syndet;
    logic       hunting;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [8:0] exp_q[$];   // {par_err, data}

    always #2.5 clk = ~clk;

    sync_hunt_rx uut (
        .clk(clk), .rst(rst), .bit_tick(bit_tick), .rxd(rxd),
        .rx_enable(rx_enable), .hunt_cmd(hunt_cmd), .len_code(len_code),
        .parity_en(parity_en), .parity_even(parity_even),
        .single_sync(single_sync), .ext_mode(ext_mode), .sync_in(sync_in),
        .sync_char1(sync_char1), .sync_char2(sync_char2),
        .status_rd(status_rd), .char_valid(char_valid),
        .char_data(char_data), .char_par_err(char_par_err),
        .syndet(syndet), .hunting(hunting)
    );

    task automatic chk(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        rxd      = b;
        bit_tick = 1'b1;
        @(negedge clk);
        bit_tick = 1'b0;
    endtask

    task automatic send_bits(input logic [7:0] v, input int n);
        for (int i = 0; i < n; i++) send_bit(v[i]);
    endtask

    task automatic pulse_hunt();
        @(negedge clk); hunt_cmd = 1'b1;
        @(negedge clk); hunt_cmd = 1'b0;
    endtask

    task automatic pulse_status();
        @(negedge clk); status_rd = 1'b1;
        @(negedge clk); status_rd = 1'b0;
    endtask

    // driver side of the scoreboard
    task automatic expect_char(input logic [7:0] d, input logic pe);
        exp_q.push_back({pe, d});
    endtask

    // monitor side of the scoreboard
    always @(negedge clk) begin
        if (!rst && char_valid) begin
            if (exp_q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R7/R11: unexpected character actual %0h expected none",
                         char_data);
            end else begin
                logic [8:0] e;
                e = exp_q.pop_front();
                chk("R7 char_data", 32'(char_data), 32'(e[7:0]));
                chk("R8 char_par_err", 32'(char_par_err), 32'(e[8]));
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 syndet", 32'(syndet), 0);
        chk("R1 hunting", 32'(hunting), 0);
        chk("R1 char_valid", 32'(char_valid), 0);

        // R2: hunt command ignored while disabled
        pulse_hunt();
        chk("R2 disabled hunt", 32'(hunting), 0);

        // single sync, 8-bit, no parity
        rx_enable = 1'b1;
        pulse_hunt();
        chk("R2 hunt entered", 32'(hunting), 1);
        send_bits(8'b0000_0101, 3);          // off-boundary lead-in
        send_bits(8'h16, 7);
        chk("R4 before last sync bit syndet", 32'(syndet), 0);
        chk("R3 still hunting", 32'(hunting), 1);
        send_bit(1'b0);
        chk("R4 syndet on match", 32'(syndet), 1);
        chk("R3 odd offset aligned", 32'(hunting), 0);
        expect_char(8'hA5, 1'b0); send_bits(8'hA5, 8);
        expect_char(8'h3C, 1'b0); send_bits(8'h3C, 8);
        repeat (3) @(negedge clk);
        chk("R9 syndet held", 32'(syndet), 1);
        pulse_status();
        chk("R9 cleared by status read", 32'(syndet), 0);

        // double sync, 5-bit, even parity; upper pattern bits differ
        len_code    = 2'd0;
        single_sync = 1'b0;
        parity_en   = 1'b1;
        parity_even = 1'b1;
        sync_char1  = 8'hE9;                 // low 5 bits 0x09
        sync_char2  = 8'hF3;                 // low 5 bits 0x13
        pulse_hunt();
        send_bits(8'h09, 5);
        chk("R6 no syndet before parity", 32'(syndet), 0);
        send_bit(1'b0);
        send_bits(8'h00, 5);                 // wrong second pattern
        chk("R5 mismatch keeps hunting", 32'(hunting), 1);
        chk("R5 mismatch no syndet", 32'(syndet), 0);
        send_bits(8'h09, 5);
        send_bit(1'b0);
        send_bits(8'h13, 5);
        chk("R6 second pattern waits for parity", 32'(syndet), 0);
        chk("R6 still hunting", 32'(hunting), 1);
        send_bit(1'b0);
        chk("R5 R3 double sync syndet", 32'(syndet), 1);
        chk("R5 aligned", 32'(hunting), 0);
        expect_char(8'h15, 1'b0); send_bits(8'h15, 5); send_bit(1'b1);
        expect_char(8'h03, 1'b1); send_bits(8'h03, 5); send_bit(1'b1);
        parity_even = 1'b0;
        expect_char(8'h07, 1'b0); send_bits(8'h07, 5); send_bit(1'b0);
        pulse_status();
        chk("R9 cleared again", 32'(syndet), 0);

        // external alignment
        len_code    = 2'd3;
        single_sync = 1'b1;
        parity_en   = 1'b0;
        sync_char1  = 8'h16;
        ext_mode    = 1'b1;
        pulse_hunt();
        send_bits(8'h16, 8);
        send_bits(8'h16, 8);
        chk("R10 pattern ignored", 32'(hunting), 1);
        chk("R10 no syndet from pattern", 32'(syndet), 0);
        @(negedge clk); sync_in = 1'b1;
        @(negedge clk);
        chk("R10 edge ends hunt", 32'(hunting), 0);
        expect_char(8'h5A, 1'b0); send_bits(8'h5A, 8);
        chk("R10 syndet stays low", 32'(syndet), 0);
        sync_in = 1'b0;

        // disable while aligned
        @(negedge clk); rx_enable = 1'b0;
        send_bits(8'hFF, 8);
        chk("R11 not hunting when off", 32'(hunting), 0);
        pulse_hunt();
        chk("R2 R11 command ignored when off", 32'(hunting), 0);
        rx_enable = 1'b1;
        ext_mode  = 1'b0;
        pulse_hunt();
        chk("R2 hunt after re-enable", 32'(hunting), 1);

        repeat (4) @(negedge clk);
        chk("R7 all characters delivered", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule